// File: doc/BRIEF.md
# Front-End Stack Pointer Delta Tracker

This unit sits after the instruction decoder. It absorbs the stack-pointer arithmetic that push, pop, call and return would otherwise need as separate add micro-operations. It keeps a signed running offset between the speculative stack pointer and the architectural one. For each stack access it patches the memory displacement so that the address is still formed from the older, unadjusted stack pointer. No stack-pointer update leaves the unit for these operations.

When an instruction names the stack pointer explicitly, as a source or as a destination, the architectural value must be current. If the tracked offset is non-zero, the unit holds the decoder for one cycle and emits a synchronisation request that carries the pending offset. Downstream logic turns that request into "stack pointer plus offset". The offset then returns to zero. A push or pop that would take the offset outside its signed range forces the same synchronisation first.

Ops flagged as branches save the offset that follows them into a small tagged checkpoint store. On a misprediction, a restore selects the saved offset by tag. A restore overrides any other action in the same cycle.

Top module: `sp_delta_tracker`

## Requirements
- R1: An accepted push-class op (kind code 1, push or call) lowers the offset by the operand size, where size in bytes is 1 << inSize. Its output displacement is inDisp plus the lowered offset, sign-extended and wrapping at the displacement width. The result appears one cycle after acceptance.
- R2: An accepted pop-class op (kind code 2, pop or return) outputs inDisp plus the offset it found. After that the offset rises by the operand size.
- R3: An accepted op of kind code 0 passes inDisp through unchanged and leaves the offset as it was.
- R4: An op of kind code 3 (explicit stack-pointer read or write) that meets a non-zero offset is held with inReady low for exactly one cycle. In the following cycle syncValid is high, syncOffset equals the offset, and the op is accepted in that same cycle.
- R5: After a sync the offset is zero, so the next stack op is patched as though no implicit updates had happened.
- R6: An op of kind code 3 that meets a zero offset is accepted at once, and no sync is emitted.
- R7: The offset is a signed 12-bit value. A push or pop whose update would leave the range -2048..2047 is stalled one cycle and preceded by a sync of the current offset. It is then applied starting from zero.
- R8: An accepted op with inBranch set stores its post-op offset under inTag. There are 4 entries. restoreValid with restoreTag reloads the offset from the entry named by restoreTag.
- R9: In a cycle with restoreValid high, any presented op is discarded. No output, no sync and no checkpoint write occur, and inReady is high.
- R10: Under reset the offset and all checkpoint entries are zero, and outValid and syncValid are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Decoded op presented |
| inReady | output | 1 | Op accepted this cycle when high with inValid |
| inKind | input | 2 | 0 other, 1 push/call, 2 pop/return, 3 explicit stack-pointer use |
| inSize | input | 2 | Operand size code, bytes = 1 << inSize |
| inDisp | input | 16 | Original memory displacement |
| inBranch | input | 1 | Op is a predicted branch; checkpoint its offset |
| inTag | input | 2 | Checkpoint tag of the branch |
| restoreValid | input | 1 | Misprediction recovery request |
| restoreTag | input | 2 | Tag of the checkpoint to restore |
| outValid | output | 1 | Patched op valid |
| outKind | output | 2 | Kind of the patched op |
| outDisp | output | 16 | Patched displacement |
| syncValid | output | 1 | Synchronisation op requested |
| syncOffset | output | 12 | Offset to add to the architectural stack pointer |

## Verification
Assertions check four properties on every cycle. Every stall is followed by a ready cycle. A sync never carries a zero offset and always leaves the offset at zero. An explicit stack-pointer op is only passed on when the offset was zero. A restore suppresses all output in the next cycle. The bench's scenarios alone show the following: the exact patched displacements, the overflow boundaries at both ends of the offset range, and the correct value coming back from each checkpoint tag.

// File: rtl/sp_delta_pkg.sv
package sp_delta_pkg;

  typedef enum logic [1:0] {
    KIND_OTHER = 2'd0,
    KIND_PUSH  = 2'd1,
    KIND_POP   = 2'd2,
    KIND_SPUSE = 2'd3
  } opKindT;

  typedef struct packed {
    logic accept;
    logic doSync;
    logic doRestore;
    logic doCkpt;
  } ctrlStrobeT;

endpackage

// File: rtl/sp_delta_ctrl.sv
module sp_delta_ctrl
  import sp_delta_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  opKindT     inKind,
  input  logic       inBranch,
  input  logic       restoreValid,
  input  logic       deltaZero,
  input  logic       pushOvf,
  input  logic       popOvf,
  output logic       inReady,
  output ctrlStrobeT strobe
);

  logic needSync;

  // A sync is needed when the explicit value is requested with a pending
  // offset, or when an implicit update would leave the offset range.
  always_comb begin
    needSync = 1'b0;
    if (inValid) begin
      unique case (inKind)
        KIND_SPUSE: needSync = !deltaZero;
        KIND_PUSH:  needSync = pushOvf;
        KIND_POP:   needSync = popOvf;
        default:    needSync = 1'b0;
      endcase
    end
  end

  always_comb begin
    strobe.doRestore = restoreValid;
    strobe.doSync    = needSync && !restoreValid;
    strobe.accept    = inValid && !needSync && !restoreValid;
    strobe.doCkpt    = strobe.accept && inBranch;
    inReady          = !needSync || restoreValid;
  end

  // The stall never lasts longer than the one sync cycle.
  AST_STALL_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |=> inReady); // R4

endmodule

// File: rtl/sp_delta_datapath.sv
module sp_delta_datapath
  import sp_delta_pkg::*;
#(
  parameter int DISP_W  = 16,
  parameter int DELTA_W = 12,
  parameter int CKPT_N  = 4,
  parameter int TAG_W   = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrobeT         strobe,
  input  opKindT             inKind,
  input  logic [1:0]         inSize,
  input  logic [DISP_W-1:0]  inDisp,
  input  logic [TAG_W-1:0]   inTag,
  input  logic [TAG_W-1:0]   restoreTag,
  output logic               deltaZero,
  output logic               pushOvf,
  output logic               popOvf,
  output logic               outValid,
  output opKindT             outKind,
  output logic [DISP_W-1:0]  outDisp,
  output logic               syncValid,
  output logic [DELTA_W-1:0] syncOffset
);

  localparam int WIDE_W = DELTA_W + 1;
  localparam int EXT_W  = DISP_W - DELTA_W;

  logic [DELTA_W-1:0] deltaQ;
  logic [WIDE_W-1:0]  deltaWide;
  logic [WIDE_W-1:0]  sizeWide;
  logic [WIDE_W-1:0]  pushSum;
  logic [WIDE_W-1:0]  popSum;
  logic [DELTA_W-1:0] nextDeltaOp;
  logic [DELTA_W-1:0] patchDelta;
  logic [DISP_W-1:0]  patchExt;
  logic [DELTA_W-1:0] ckptMem [CKPT_N];

  // One extra bit makes the range check a sign-bit comparison.
  always_comb begin
    deltaWide = {deltaQ[DELTA_W-1], deltaQ};
    sizeWide  = WIDE_W'(1) << inSize;
    pushSum   = deltaWide - sizeWide;
    popSum    = deltaWide + sizeWide;
    pushOvf   = pushSum[WIDE_W-1] != pushSum[DELTA_W-1];
    popOvf    = popSum[WIDE_W-1] != popSum[DELTA_W-1];
    deltaZero = deltaQ == '0;
  end

  // A push addresses with the lowered offset, a pop with the offset it found.
  always_comb begin
    unique case (inKind)
      KIND_PUSH: begin
        nextDeltaOp = pushSum[DELTA_W-1:0];
        patchDelta  = pushSum[DELTA_W-1:0];
      end
      KIND_POP: begin
        nextDeltaOp = popSum[DELTA_W-1:0];
        patchDelta  = deltaQ;
      end
      default: begin
        nextDeltaOp = deltaQ;
        patchDelta  = '0;
      end
    endcase
    patchExt = {{EXT_W{patchDelta[DELTA_W-1]}}, patchDelta};
  end

  // Checkpoint store: one register per tag.
  for (genvar gi = 0; gi < CKPT_N; gi++) begin : g_ckpt
    always_ff @(posedge clk) begin
      if (!rstN) begin
        ckptMem[gi] <= '0;
      end else if (strobe.doCkpt && inTag == TAG_W'(gi)) begin
        ckptMem[gi] <= nextDeltaOp;
      end
    end
  end

  // Offset register: restore first, then sync, then normal updates.
  always_ff @(posedge clk) begin
    if (!rstN) begin
      deltaQ <= '0;
    end else if (strobe.doRestore) begin
      deltaQ <= ckptMem[restoreTag];
    end else if (strobe.doSync) begin
      deltaQ <= '0;
    end else if (strobe.accept) begin
      deltaQ <= nextDeltaOp;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid   <= 1'b0;
      outKind    <= KIND_OTHER;
      outDisp    <= '0;
      syncValid  <= 1'b0;
      syncOffset <= '0;
    end else begin
      outValid  <= strobe.accept;
      syncValid <= strobe.doSync;
      if (strobe.accept) begin
        outKind <= inKind;
        outDisp <= inDisp + patchExt;
      end
      if (strobe.doSync) begin
        syncOffset <= deltaQ;
      end
    end
  end

  AST_SYNC_NONZERO: assert property (@(posedge clk) disable iff (!rstN)
    syncValid |-> syncOffset != '0); // R6

  AST_ZERO_AFTER_SYNC: assert property (@(posedge clk) disable iff (!rstN)
    syncValid |-> deltaQ == '0); // R5

  AST_SPUSE_CLEAN: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outKind == KIND_SPUSE) |-> $past(deltaQ) == '0); // R4

endmodule

// File: rtl/sp_delta_tracker.sv
module sp_delta_tracker
  import sp_delta_pkg::*;
#(
  parameter int DISP_W  = 16,
  parameter int DELTA_W = 12,
  parameter int CKPT_N  = 4,
  localparam int TAG_W  = (CKPT_N > 1) ? $clog2(CKPT_N) : 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               inValid,
  output logic               inReady,
  input  logic [1:0]         inKind,
  input  logic [1:0]         inSize,
  input  logic [DISP_W-1:0]  inDisp,
  input  logic               inBranch,
  input  logic [TAG_W-1:0]   inTag,
  input  logic               restoreValid,
  input  logic [TAG_W-1:0]   restoreTag,
  output logic               outValid,
  output logic [1:0]         outKind,
  output logic [DISP_W-1:0]  outDisp,
  output logic               syncValid,
  output logic [DELTA_W-1:0] syncOffset
);

  ctrlStrobeT strobe;
  opKindT     kindIn;
  opKindT     kindOut;
  logic       deltaZero;
  logic       pushOvf;
  logic       popOvf;

  assign kindIn  = opKindT'(inKind);
  assign outKind = kindOut;

  sp_delta_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .inValid      (inValid),
    .inKind       (kindIn),
    .inBranch     (inBranch),
    .restoreValid (restoreValid),
    .deltaZero    (deltaZero),
    .pushOvf      (pushOvf),
    .popOvf       (popOvf),
    .inReady      (inReady),
    .strobe       (strobe)
  );

  sp_delta_datapath #(
    .DISP_W  (DISP_W),
    .DELTA_W (DELTA_W),
    .CKPT_N  (CKPT_N),
    .TAG_W   (TAG_W)
  ) u_datapath (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .inKind     (kindIn),
    .inSize     (inSize),
    .inDisp     (inDisp),
    .inTag      (inTag),
    .restoreTag (restoreTag),
    .deltaZero  (deltaZero),
    .pushOvf    (pushOvf),
    .popOvf     (popOvf),
    .outValid   (outValid),
    .outKind    (kindOut),
    .outDisp    (outDisp),
    .syncValid  (syncValid),
    .syncOffset (syncOffset)
  );

  AST_RESTORE_FLUSH: assert property (@(posedge clk) disable iff (!rstN)
    $past(restoreValid) |-> (!outValid && !syncValid)); // R9

endmodule

// File: tb/sp_delta_tracker_bench.sv
`timescale 1ns/1ps
module sp_delta_tracker_bench;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        inValid = 1'b0;
  logic        inReady;
  logic [1:0]  inKind = 2'd0;
  logic [1:0]  inSize = 2'd0;
  logic [15:0] inDisp = 16'd0;
  logic        inBranch = 1'b0;
  logic [1:0]  inTag = 2'd0;
  logic        restoreValid = 1'b0;
  logic [1:0]  restoreTag = 2'd0;
  logic        outValid;
  logic [1:0]  outKind;
  logic [15:0] outDisp;
  logic        syncValid;
  logic [11:0] syncOffset;

  int checks = 0;
  int fails = 0;

  // Reference model state
  int          mDelta = 0;
  int          mCk [4] = '{0, 0, 0, 0};
  bit          eOutValid;
  logic [1:0]  eOutKind;
  logic [15:0] eOutDisp;
  bit          eSync;
  logic [11:0] eSyncOff;

  always #2.5 clk = ~clk;

  sp_delta_tracker u_sp_delta_tracker (
    .clk (clk), .rstN (rstN),
    .inValid (inValid), .inReady (inReady), .inKind (inKind),
    .inSize (inSize), .inDisp (inDisp), .inBranch (inBranch),
    .inTag (inTag), .restoreValid (restoreValid), .restoreTag (restoreTag),
    .outValid (outValid), .outKind (outKind), .outDisp (outDisp),
    .syncValid (syncValid), .syncOffset (syncOffset)
  );

  task automatic check(string req, string what, longint act, longint exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // One clock of stimulus plus a comparison against the model.
  task automatic cycle(input logic v, input logic [1:0] kind, input logic [1:0] sz,
                       input logic [15:0] disp, input logic br, input logic [1:0] tag,
                       input logic rv, input logic [1:0] rtag, input string req,
                       output bit acc);
    int  bytes;
    bit  need;
    bit  eReady;
    inValid = v; inKind = kind; inSize = sz; inDisp = disp;
    inBranch = br; inTag = tag; restoreValid = rv; restoreTag = rtag;
    bytes = 1 << sz;
    need = v && ((kind == 2'd3 && mDelta != 0) ||
                 (kind == 2'd1 && mDelta - bytes < -2048) ||
                 (kind == 2'd2 && mDelta + bytes > 2047));
    eReady = !need || rv;
    eOutValid = 0; eSync = 0; acc = 0;
    if (rv) begin
      mDelta = mCk[rtag];
      acc = 1;
    end else if (need) begin
      eSync = 1;
      eSyncOff = 12'(mDelta);
      mDelta = 0;
    end else if (v) begin
      acc = 1;
      eOutValid = 1;
      eOutKind = kind;
      if (kind == 2'd1) begin
        mDelta = mDelta - bytes;
        eOutDisp = disp + 16'(mDelta);
      end else if (kind == 2'd2) begin
        eOutDisp = disp + 16'(mDelta);
        mDelta = mDelta + bytes;
      end else begin
        eOutDisp = disp;
      end
      if (br) mCk[tag] = mDelta;
    end else begin
      acc = 1;
    end
    #1;
    check(req, "inReady", longint'(inReady), longint'(eReady));
    @(posedge clk);
    #1;
    check(req, "outValid", longint'(outValid), longint'(eOutValid));
    check(req, "syncValid", longint'(syncValid), longint'(eSync));
    if (eOutValid) begin
      check(req, "outDisp", longint'(outDisp), longint'(eOutDisp));
      check(req, "outKind", longint'(outKind), longint'(eOutKind));
    end
    if (eSync) check(req, "syncOffset", longint'(syncOffset), longint'(eSyncOff));
    @(negedge clk);
  endtask

  task automatic issue(input logic [1:0] kind, input logic [1:0] sz,
                       input logic [15:0] disp, input logic br, input logic [1:0] tag,
                       input string req);
    bit acc = 0;
    while (!acc) cycle(1'b1, kind, sz, disp, br, tag, 1'b0, 2'd0, req, acc);
  endtask

  task automatic idle(input string req);
    bit acc;
    cycle(1'b0, 2'd0, 2'd0, 16'd0, 1'b0, 2'd0, 1'b0, 2'd0, req, acc);
  endtask

  task automatic restore(input logic v, input logic [1:0] kind, input logic [1:0] rtag,
                         input string req);
    bit acc;
    cycle(v, kind, 2'd2, 16'd0, 1'b1, 2'd3, 1'b1, rtag, req, acc);
  endtask

  initial begin : watchdog
    #(5.0 * 200000);
    checks++;
    fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R10: reset state
    check("R10", "outValid", longint'(outValid), 0);
    check("R10", "syncValid", longint'(syncValid), 0);
    check("R10", "inReady", longint'(inReady), 1);
    rstN = 1'b1;
    @(negedge clk);

    issue(2'd1, 2'd2, 16'd0, 1'b0, 2'd0, "R1");   // delta -4
    issue(2'd1, 2'd2, 16'd4, 1'b0, 2'd0, "R1");   // delta -8
    issue(2'd1, 2'd0, 16'd10, 1'b0, 2'd0, "R1");  // 1 byte, delta -9
    issue(2'd0, 2'd2, 16'd100, 1'b0, 2'd0, "R3");
    issue(2'd2, 2'd0, 16'd0, 1'b0, 2'd0, "R2");   // delta -8
    issue(2'd2, 2'd2, 16'd0, 1'b0, 2'd0, "R2");   // delta -4
    issue(2'd3, 2'd2, 16'd3, 1'b0, 2'd0, "R4");   // stall + sync -4
    issue(2'd2, 2'd1, 16'd8, 1'b0, 2'd0, "R5");   // disp 8, delta 2
    issue(2'd2, 2'd1, 16'd0, 1'b0, 2'd0, "R2");   // delta 4
    issue(2'd3, 2'd2, 16'd0, 1'b0, 2'd0, "R4");
    issue(2'd3, 2'd2, 16'd7, 1'b0, 2'd0, "R6");   // zero delta, no stall
    idle("R3");

    // R7: drive the offset to both range limits
    for (int i = 0; i < 257; i++) issue(2'd1, 2'd3, 16'd0, 1'b0, 2'd0, "R7");
    for (int i = 0; i < 260; i++) issue(2'd2, 2'd3, 16'd0, 1'b0, 2'd0, "R7");
    issue(2'd2, 2'd0, 16'd0, 1'b0, 2'd0, "R7");
    issue(2'd3, 2'd2, 16'd0, 1'b0, 2'd0, "R4");

    // R8: checkpoint and restore
    issue(2'd1, 2'd2, 16'd0, 1'b1, 2'd1, "R8");   // ck1 = -4
    issue(2'd1, 2'd3, 16'd0, 1'b1, 2'd2, "R8");   // ck2 = -12
    issue(2'd1, 2'd1, 16'd0, 1'b0, 2'd0, "R8");   // -14
    restore(1'b0, 2'd0, 2'd1, "R8");
    issue(2'd2, 2'd2, 16'd0, 1'b0, 2'd0, "R8");   // disp -4
    restore(1'b0, 2'd0, 2'd2, "R8");
    issue(2'd2, 2'd2, 16'd0, 1'b0, 2'd0, "R8");   // disp -12
    issue(2'd0, 2'd0, 16'd5, 1'b1, 2'd0, "R8");   // ck0 = -8
    issue(2'd1, 2'd3, 16'd0, 1'b0, 2'd0, "R8");
    restore(1'b0, 2'd0, 2'd0, "R8");
    issue(2'd1, 2'd0, 16'd0, 1'b0, 2'd0, "R8");   // disp -9

    // R9: restore beats sync and ordinary ops in the same cycle
    restore(1'b1, 2'd3, 2'd2, "R9");              // delta -12, nonzero SP use dropped
    issue(2'd2, 2'd0, 16'd0, 1'b0, 2'd0, "R9");   // disp -12, ck3 untouched
    restore(1'b1, 2'd1, 2'd3, "R9");              // ck3 still 0
    issue(2'd3, 2'd2, 16'd1, 1'b0, 2'd0, "R9");   // no stall: offset 0
    idle("R9");
    idle("R10");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule